// File: doc/BRIEF.md
# LCD Common/Segment Drive Sequencer

This block produces 2-bit level-select codes for the common and segment pins of a small multiplexed LCD. An analog stage outside the block turns each code into one of four supply rails. The block supports four multiplex ratios: static, 1/2, 1/3 and 1/4. A programmable divider paces the scan. Each divider tick moves the active common on by one. When the last common in use has been scanned, the alternation flag `m_o` inverts, so over two frames the panel sees no net DC bias.

The display runs only when the activate input is set and the current power mode allows it. In active and sleep modes, activation alone is enough. In the three low-power modes that run from the watch clock, the selected operating clock must also be derived from the watch clock. In reset, standby and module standby the display is dark. In both standby modes the drive-power enable is forced low whatever the power-switch input says.

While the display is stopped, every pin code reads VSS and the scan state is held cleared. Each later start therefore begins at common 0 with `m_o` low.

Top module: `lcd_drive_seq`

## Requirements
- R1: While the display is not running (`disp_on_o`=0), every `com_lvl_o` and `seg_lvl_o` field is 2'b00 (VSS). The scan index, `m_o` and the divider count are cleared at each clock edge during that time, so a new start begins at common 0 with `m_o`=0.
- R2: Power mode codes are 0 reset, 1 active, 2 sleep, 3 watch, 4 subactive, 5 subsleep, 6 standby and 7 module standby. `disp_on_o` is 0 whenever `act_i`=0, and also in reset, standby and module standby. In active and sleep it equals `act_i`.
- R3: In watch, subactive and subsleep, the display runs only when `clk_sel_i` is nonzero. The codes are 0 system clock, 1 watch clock, 2 watch/2 and 3 watch/4.
- R4: `drive_pwr_o` is 0 in standby and module standby, and equals `psw_i` in every other mode.
- R5: While running, the scan steps once every `div_limit_i`+1 clock cycles. The first step falls on the (`div_limit_i`+1)-th rising edge after start.
- R6: Duty codes are 0 static, 1 half, 2 third and 3 quarter. The scan index `com_idx_o` counts 0 up to the duty code and then wraps to 0. `m_o` inverts exactly on each wrap and holds otherwise.
- R7: Level codes are 00 VSS, 01 V1, 10 V2 and 11 V3. In static mode, common 0 gives V1 when `m_o`=0 and VSS when `m_o`=1.
- R8: At half duty, the selected common gives V1 when `m_o`=0 and VSS when `m_o`=1. The non-selected common gives V2.
- R9: In static and half duty, a segment gives V1 when its data bit equals `m_o`, and VSS otherwise.
- R10: At third and quarter duty, a common in use gives V3, V2, V1 or VSS for (selected, `m_o`) = 00, 01, 10 or 11. A segment gives V2, V3, VSS or V1 for (data, `m_o`) = 00, 01, 10 or 11.
- R11: A common whose index is above the duty code always gives VSS.
- R12: Segment s takes its data from bit `com_idx_o`*NUM_SEG+s of `seg_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Display activate |
| pmode_i | input | 3 | Current power mode code |
| clk_sel_i | input | 2 | Operating clock source code |
| psw_i | input | 1 | Power-switch setting for the LCD drive supply |
| duty_i | input | 2 | Multiplex ratio code |
| div_limit_i | input | DIV_W | Divider terminal count; one scan step per div_limit_i+1 cycles |
| seg_data_i | input | NUM_COM*NUM_SEG | Display data; bit c*NUM_SEG+s drives segment s while common c is scanned |
| com_lvl_o | output | NUM_COM*2 | Level code per common, common c at bits [2c+1:2c] |
| seg_lvl_o | output | NUM_SEG*2 | Level code per segment, segment s at bits [2s+1:2s] |
| com_idx_o | output | IDX_W | Common currently selected |
| m_o | output | 1 | Alternation flag |
| disp_on_o | output | 1 | Display running |
| drive_pwr_o | output | 1 | LCD drive power enable |

## Verification
The hardest state to reach from the ports is a scan stopped in the middle of a frame, with `m_o` already inverted and the index partway through. To get there, the bench lets a quarter-duty scan run past its first wrap. It then drops `act_i`, and on a later run switches the power mode to standby instead. After each stop it checks that all outputs read VSS straight away, that the index and `m_o` are cleared on the next edge, and that a restart begins from common 0. Divider pacing is checked by sampling at every edge with nonzero `div_limit_i`, so an off-by-one step time would be seen.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LVL_VSS = 2'b00,
    LVL_V1  = 2'b01,
    LVL_V2  = 2'b10,
    LVL_V3  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    DUTY_STATIC  = 2'd0,
    DUTY_HALF    = 2'd1,
    DUTY_THIRD   = 2'd2,
    DUTY_QUARTER = 2'd3
  } duty_e;

  typedef enum logic [2:0] {
    PM_RESET    = 3'd0,
    PM_ACTIVE   = 3'd1,
    PM_SLEEP    = 3'd2,
    PM_WATCH    = 3'd3,
    PM_SUBACT   = 3'd4,
    PM_SUBSLEEP = 3'd5,
    PM_STANDBY  = 3'd6,
    PM_MODSTBY  = 3'd7
  } pmode_e;

  localparam logic [1:0] CS_SYS = 2'd0;
endpackage

// File: rtl/lcd_run_gate.sv
module lcd_run_gate
  import lcd_seq_pkg::*;
(
  input  logic       act_i,
  input  logic [2:0] pmode_i,
  input  logic [1:0] clk_sel_i,
  input  logic       psw_i,
  output logic       run_o,
  output logic       drive_pwr_o
);
  pmode_e pm;
  logic   mode_ok;
  logic   stby;

  always_comb begin
    pm = pmode_e'(pmode_i);
    unique case (pm)
      PM_ACTIVE, PM_SLEEP:              mode_ok = 1'b1;
      PM_WATCH, PM_SUBACT, PM_SUBSLEEP: mode_ok = (clk_sel_i != CS_SYS);
      default:                          mode_ok = 1'b0;
    endcase
    stby        = (pm == PM_STANDBY) || (pm == PM_MODSTBY);
    run_o       = act_i & mode_ok;
    drive_pwr_o = psw_i & ~stby;
  end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int DIV_W   = 8,
  parameter int NUM_COM = 4,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       duty_i,
  input  logic [DIV_W-1:0] div_limit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             m_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             m_q;
  logic             tick;
  logic             last;

  assign tick = (cnt_q == div_limit_i);
  assign last = (idx_q >= IDX_W'(duty_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      m_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      idx_q <= '0;
      m_q   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      if (last) begin
        idx_q <= '0;
        m_q   <= ~m_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idx_o = idx_q;
  assign m_o   = m_q;

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (idx_q == '0 && !m_q && cnt_q == '0)); // R1
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !last) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R5
  AST_M_FLIP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && last) |=> (m_q != $past(m_q) && idx_q == '0)); // R6
  AST_M_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(tick && last)) |=> $stable(m_q)); // R6
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic                       run_i,
  input  logic [1:0]                 duty_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       m_i,
  input  logic [NUM_COM*NUM_SEG-1:0] seg_data_i,
  output logic [NUM_COM*2-1:0]       com_lvl_o,
  output logic [NUM_SEG*2-1:0]       seg_lvl_o
);
  function automatic lvl_e com_code(duty_e d, logic sel, logic m);
    unique case (d)
      DUTY_STATIC: return m ? LVL_VSS : LVL_V1;
      DUTY_HALF:   return sel ? (m ? LVL_VSS : LVL_V1) : LVL_V2;
      default: begin
        unique case ({sel, m})
          2'b00:   return LVL_V3;
          2'b01:   return LVL_V2;
          2'b10:   return LVL_V1;
          default: return LVL_VSS;
        endcase
      end
    endcase
  endfunction

  function automatic lvl_e seg_code(duty_e d, logic dat, logic m);
    if (d == DUTY_STATIC || d == DUTY_HALF) return (dat == m) ? LVL_V1 : LVL_VSS;
    unique case ({dat, m})
      2'b00:   return LVL_V2;
      2'b01:   return LVL_V3;
      2'b10:   return LVL_VSS;
      default: return LVL_V1;
    endcase
  endfunction

  duty_e              duty;
  logic [NUM_SEG-1:0] row;

  always_comb begin
    duty = duty_e'(duty_i);
    row  = seg_data_i[idx_i*NUM_SEG +: NUM_SEG];
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (!run_i || c > int'(duty_i)) com_lvl_o[2*c +: 2] = LVL_VSS;
      else com_lvl_o[2*c +: 2] = com_code(duty, (idx_i == IDX_W'(c)), m_i);
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_comb begin
      if (!run_i) seg_lvl_o[2*s +: 2] = LVL_VSS;
      else seg_lvl_o[2*s +: 2] = seg_code(duty, row[s], m_i);
    end
  end
endmodule

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq
  import lcd_seq_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_i,
  input  logic [2:0]                 pmode_i,
  input  logic [1:0]                 clk_sel_i,
  input  logic                       psw_i,
  input  logic [1:0]                 duty_i,
  input  logic [DIV_W-1:0]           div_limit_i,
  input  logic [NUM_COM*NUM_SEG-1:0] seg_data_i,
  output logic [NUM_COM*2-1:0]       com_lvl_o,
  output logic [NUM_SEG*2-1:0]       seg_lvl_o,
  output logic [IDX_W-1:0]           com_idx_o,
  output logic                       m_o,
  output logic                       disp_on_o,
  output logic                       drive_pwr_o
);
  logic run;

  lcd_run_gate u_gate (
    .act_i       (act_i),
    .pmode_i     (pmode_i),
    .clk_sel_i   (clk_sel_i),
    .psw_i       (psw_i),
    .run_o       (run),
    .drive_pwr_o (drive_pwr_o)
  );

  lcd_scan_timer #(.DIV_W(DIV_W), .NUM_COM(NUM_COM)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .duty_i      (duty_i),
    .div_limit_i (div_limit_i),
    .idx_o       (com_idx_o),
    .m_o         (m_o)
  );

  lcd_level_map #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_map (
    .run_i      (run),
    .duty_i     (duty_i),
    .idx_i      (com_idx_o),
    .m_i        (m_o),
    .seg_data_i (seg_data_i),
    .com_lvl_o  (com_lvl_o),
    .seg_lvl_o  (seg_lvl_o)
  );

  assign disp_on_o = run;

  AST_STOP_VSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_o |-> (com_lvl_o == '0 && seg_lvl_o == '0)); // R1
  AST_NO_ACT_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i || pmode_i == 3'd0) |-> !disp_on_o); // R2
  AST_STBY_PWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_i == 3'd6 || pmode_i == 3'd7) |-> (!drive_pwr_o && !disp_on_o)); // R4
  AST_SYSCLK_LOWPWR_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_i inside {3'd3, 3'd4, 3'd5} && clk_sel_i == 2'd0) |-> !disp_on_o); // R3
  AST_UNUSED_COM_VSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == 2'd0) |-> (com_lvl_o[NUM_COM*2-1:2] == '0)); // R11
endmodule

// File: tb/lcd_drive_seq_bench.sv
module lcd_drive_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          act_i = 1'b0;
  logic [2:0]    pmode_i = 3'd1;
  logic [1:0]    clk_sel_i = 2'd0;
  logic          psw_i = 1'b1;
  logic [1:0]    duty_i = 2'd0;
  logic [7:0]    div_limit_i = 8'd0;
  logic [NC*NS-1:0] seg_data_i = '0;
  logic [NC*2-1:0]  com_lvl_o;
  logic [NS*2-1:0]  seg_lvl_o;
  logic [1:0]    com_idx_o;
  logic          m_o;
  logic          disp_on_o;
  logic          drive_pwr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lcd_drive_seq u_lcd_drive_seq (
    .clk_i, .rst_ni, .act_i, .pmode_i, .clk_sel_i, .psw_i, .duty_i,
    .div_limit_i, .seg_data_i, .com_lvl_o, .seg_lvl_o, .com_idx_o,
    .m_o, .disp_on_o, .drive_pwr_o
  );

  // {act, pmode, clk_sel, psw, exp_on, exp_pwr}
  localparam int NV = 13;
  localparam logic [8:0] GATE_VEC [NV] = '{
    {1'b1, 3'd0, 2'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd1, 2'd0, 1'b1, 1'b1, 1'b1},
    {1'b0, 3'd1, 2'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd2, 2'd3, 1'b0, 1'b1, 1'b0},
    {1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd3, 2'd1, 1'b1, 1'b1, 1'b1},
    {1'b1, 3'd4, 2'd2, 1'b0, 1'b1, 1'b0},
    {1'b1, 3'd4, 2'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd5, 2'd3, 1'b1, 1'b1, 1'b1},
    {1'b0, 3'd5, 2'd3, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd6, 2'd1, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd7, 2'd1, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic logic [1:0] e_com(int duty, int c, int idx, bit m);
    bit sel = (c == idx);
    if (c > duty) return 2'b00;                 // R11
    if (duty == 0) return m ? 2'b00 : 2'b01;    // R7
    if (duty == 1) return sel ? (m ? 2'b00 : 2'b01) : 2'b10; // R8
    case ({sel, m})                             // R10
      2'b00:   return 2'b11;
      2'b01:   return 2'b10;
      2'b10:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] e_seg(int duty, bit d, bit m);
    if (duty < 2) return (d == m) ? 2'b01 : 2'b00; // R9
    case ({d, m})                                  // R10
      2'b00:   return 2'b10;
      2'b01:   return 2'b11;
      2'b10:   return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  task automatic check_levels(int duty, int idx, bit m);
    logic [NC*2-1:0] ec;
    logic [NS*2-1:0] es;
    for (int c = 0; c < NC; c++) ec[2*c +: 2] = e_com(duty, c, idx, m);
    for (int s = 0; s < NS; s++) es[2*s +: 2] = e_seg(duty, seg_data_i[idx*NS + s], m); // R12
    check("R7/R8/R10/R11 common levels", 32'(com_lvl_o), 32'(ec));
    check("R9/R10/R12 segment levels", 32'(seg_lvl_o), 32'(es));
  endtask

  // start from stopped, run nsteps edges, check each
  task automatic scan_run(int duty, int divl, logic [31:0] data, int nsteps);
    @(negedge clk_i);
    act_i = 1'b0; pmode_i = 3'd1; duty_i = 2'(duty);
    div_limit_i = 8'(divl); seg_data_i = data;
    @(negedge clk_i);
    act_i = 1'b1;
    #1;
    for (int k = 0; k <= nsteps; k++) begin
      int step = k / (divl + 1);
      int idx  = step % (duty + 1);
      bit m    = ((step / (duty + 1)) % 2) == 1;
      check("R5/R6 scan index", 32'(com_idx_o), 32'(idx));
      check("R6 alternation flag", 32'(m_o), 32'(m));
      check_levels(duty, idx, m);
      if (k < nsteps) begin
        @(negedge clk_i);
        #1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    act_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // reset state
    check("R1 reset index", 32'(com_idx_o), 32'd0);
    check("R1 reset flag", 32'(m_o), 32'd0);
    rst_ni = 1'b1;
    act_i = 1'b0;
    @(negedge clk_i);
    check("R1 stopped commons VSS", 32'(com_lvl_o), 32'd0);
    check("R1 stopped segments VSS", 32'(seg_lvl_o), 32'd0);

    // gating table: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      {act_i, pmode_i, clk_sel_i, psw_i} = GATE_VEC[v][8:2];
      #1;
      check($sformatf("R2/R3 display enable vec %0d", v), 32'(disp_on_o), 32'(GATE_VEC[v][1]));
      check($sformatf("R4 drive power vec %0d", v), 32'(drive_pwr_o), 32'(GATE_VEC[v][0]));
      if (!GATE_VEC[v][1]) begin
        check("R1 dark commons", 32'(com_lvl_o), 32'd0);
        check("R1 dark segments", 32'(seg_lvl_o), 32'd0);
      end
    end

    // scans across duties and divider settings
    clk_sel_i = 2'd0; psw_i = 1'b1;
    scan_run(0, 0, 32'hA5C3_0F96, 5);
    scan_run(1, 0, 32'h3C5A_69F0, 9);
    scan_run(2, 1, 32'h0F1E_2D3C, 14);
    scan_run(3, 0, 32'h8142_24FF, 10);
    scan_run(3, 2, 32'hDEAD_BEEF, 26);

    // R1: stop mid-frame by act, then restart at common 0
    scan_run(3, 0, 32'h1234_5678, 6);
    @(negedge clk_i);
    act_i = 1'b0;
    #1;
    check("R1 mid-frame stop commons", 32'(com_lvl_o), 32'd0);
    check("R1 mid-frame stop segments", 32'(seg_lvl_o), 32'd0);
    @(negedge clk_i);
    check("R1 index cleared", 32'(com_idx_o), 32'd0);
    check("R1 flag cleared", 32'(m_o), 32'd0);
    act_i = 1'b1;
    #1;
    check_levels(3, 0, 1'b0);
    @(negedge clk_i);
    check("R1 restart steps from 0", 32'(com_idx_o), 32'd1);

    // R1/R4: standby entered mid-frame
    scan_run(2, 0, 32'h00FF_55AA, 4);
    @(negedge clk_i);
    pmode_i = 3'd6;
    #1;
    check("R4 standby power off", 32'(drive_pwr_o), 32'd0);
    check("R1 standby commons", 32'(com_lvl_o), 32'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 standby index held", 32'(com_idx_o), 32'd0);
    check("R1 standby flag held", 32'(m_o), 32'd0);

    // R3: watch mode on watch/4 keeps scanning
    @(negedge clk_i);
    pmode_i = 3'd3; clk_sel_i = 2'd3; duty_i = 2'd1; div_limit_i = 8'd0;
    #1;
    check("R3 watch mode on", 32'(disp_on_o), 32'd1);
    @(negedge clk_i);
    check("R3 watch mode steps", 32'(com_idx_o), 32'd1);

    finish_run();
  end
endmodule